// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block sits in the decode stage of a five-stage in-order pipeline. It decides whether the instruction now in decode must wait one cycle behind a load that is one stage ahead of it. It compares each source register field of the decode-stage instruction with the destination of the instruction in execute. The instruction in decode must read that field, the execute-stage instruction must be a load, and the destination must not be register zero. When all of these hold, the block freezes the program counter and the fetch/decode register and sends a nop into execute in place of the decoded control word. The dependent instruction then picks up the loaded value one cycle later through the memory-to-ALU forwarding path, which lies outside this block.

A store whose only link to the load is its write-data register is let through without a stall, because the memory-to-memory forwarding path supplies that value in time. A store whose base-address register depends on the load is still held. An internal one-bit guard makes each stall last exactly one cycle. The cycle after a stall can never stall again, even if the execute-stage inputs have not yet changed.

Top module: `ldhaz_interlock`

## Requirements
- R1: When `ex_is_load` is 1, `ex_rd` is nonzero, source 0 is flagged as used and its field equals `ex_rd`, then in that same cycle `bubble` is 1 and `pc_write` and `ifid_write` are 0, provided no stall was issued in the previous cycle.
- R2: The rule of R1 also applies to source 1 when `id_is_store` is 0. Source 1 occupies bits [2*REG_AW-1:REG_AW] of `id_rs_addr`, and source 0 occupies bits [REG_AW-1:0].
- R3: When `ex_is_load` is 0, there is no stall (`bubble`=0, `pc_write`=1, `ifid_write`=1), whatever the register fields hold.
- R4: When no used source field equals `ex_rd`, there is no stall.
- R5: When `ex_rd` is 0, there is never a stall.
- R6: A source whose bit in `id_rs_used` is 0 never causes a stall, even if its field equals `ex_rd`.
- R7: When `id_is_store` is 1, a match on source 1 (the store write-data register) causes no stall.
- R8: When `id_is_store` is 1, a match on source 0 (the store base-address register) still causes a stall.
- R9: While `bubble` is 1, `idex_ctrl` is all zeros. In every other cycle, `idex_ctrl` equals `id_ctrl`.
- R10: A stall never lasts more than one cycle. In the cycle after `bubble` was 1, `bubble` is 0, even if the hazard condition still holds. The cycle after that may stall again.
- R11: After synchronous reset with idle inputs, `pc_write`=1, `ifid_write`=1, `bubble`=0, and the first hazard after reset stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs_addr | input | NUM_SRC*REG_AW | Decode-stage source register fields, source 0 in the low bits |
| id_rs_used | input | NUM_SRC | Per-source flag: the decoded instruction reads this field |
| id_is_store | input | 1 | Decode-stage instruction is a store |
| id_ctrl | input | CTRL_W | Decoded control word headed for the ID/EX register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_rd | input | REG_AW | Execute-stage destination register |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Fetch/decode register update enable |
| bubble | output | 1 | A nop is being sent into execute this cycle |
| idex_ctrl | output | CTRL_W | Control word for ID/EX, zeroed during a stall |

## Verification
The stall decision, the two enables and the masked control word are all combinational from the inputs. They are due in the same cycle as the stimulus, so the bench drives its inputs just after a rising edge and samples every output at the following falling edge. The one-cycle guard is the only register. Its effect is due one edge after a stall, so the bench carries its own record of whether the previous cycle stalled and uses it in the next cycle's expected value. Directed sequences hold a hazard across three consecutive cycles to check the stall, release, stall pattern.

// File: rtl/ldhaz_pkg.sv
package ldhaz_pkg;

  typedef enum logic {
    GUARD_OPEN  = 1'b0,
    GUARD_SPENT = 1'b1
  } guard_e;

  function automatic logic src_exempt(input int idx, input int data_idx, input logic is_store);
    return is_store && (idx == data_idx);
  endfunction

endpackage

// File: rtl/ldhaz_src_match.sv
module ldhaz_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs,
  input  logic              used,
  input  logic              exempt,
  input  logic [REG_AW-1:0] ex_rd,
  output logic              hit
);
  logic rd_live;
  assign rd_live = |ex_rd;
  assign hit = used && rd_live && !exempt && (rs == ex_rd);
endmodule

// File: rtl/ldhaz_stall_ctrl.sv
module ldhaz_stall_ctrl
  import ldhaz_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_is_load,
  input  logic [NUM_SRC-1:0] hits,
  output logic               stall
);
  guard_e guard_q;
  logic   hazard;

  assign hazard = ex_is_load && (|hits);
  assign stall  = hazard && (guard_q == GUARD_OPEN);

  always_ff @(posedge clk) begin
    if (rst) guard_q <= GUARD_OPEN;
    else     guard_q <= stall ? GUARD_SPENT : GUARD_OPEN;
  end
endmodule

// File: rtl/ldhaz_bubble_mux.sv
module ldhaz_bubble_mux #(
  parameter int CTRL_W = 8
) (
  input  logic              stall,
  input  logic [CTRL_W-1:0] id_ctrl,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              bubble,
  output logic [CTRL_W-1:0] idex_ctrl
);
  always_comb begin
    pc_write   = !stall;
    ifid_write = !stall;
    bubble     = stall;
    idex_ctrl  = stall ? '0 : id_ctrl;
  end
endmodule

// File: rtl/ldhaz_interlock.sv
module ldhaz_interlock
  import ldhaz_pkg::*;
#(
  parameter int REG_AW         = 5,
  parameter int NUM_SRC        = 2,
  parameter int CTRL_W         = 8,
  parameter int STORE_DATA_SRC = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC*REG_AW-1:0] id_rs_addr,
  input  logic [NUM_SRC-1:0]        id_rs_used,
  input  logic                      id_is_store,
  input  logic [CTRL_W-1:0]         id_ctrl,
  input  logic                      ex_is_load,
  input  logic [REG_AW-1:0]         ex_rd,
  output logic                      pc_write,
  output logic                      ifid_write,
  output logic                      bubble,
  output logic [CTRL_W-1:0]         idex_ctrl
);
  logic [NUM_SRC-1:0] hits;
  logic               stall;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic exempt;
    assign exempt = src_exempt(i, STORE_DATA_SRC, id_is_store);
    ldhaz_src_match #(.REG_AW(REG_AW)) u_match (
      .rs     (id_rs_addr[i*REG_AW +: REG_AW]),
      .used   (id_rs_used[i]),
      .exempt (exempt),
      .ex_rd  (ex_rd),
      .hit    (hits[i])
    );
  end

  ldhaz_stall_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ex_is_load (ex_is_load),
    .hits       (hits),
    .stall      (stall)
  );

  ldhaz_bubble_mux #(.CTRL_W(CTRL_W)) u_mux (
    .stall      (stall),
    .id_ctrl    (id_ctrl),
    .pc_write   (pc_write),
    .ifid_write (ifid_write),
    .bubble     (bubble),
    .idex_ctrl  (idex_ctrl)
  );
endmodule

// File: rtl/ldhaz_interlock_chk.sv
module ldhaz_interlock_chk #(
  parameter int REG_AW = 5,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ex_is_load,
  input logic [REG_AW-1:0] ex_rd,
  input logic [CTRL_W-1:0] id_ctrl,
  input logic              pc_write,
  input logic              ifid_write,
  input logic              bubble,
  input logic [CTRL_W-1:0] idex_ctrl
);
  AST_ENABLES_FROZEN: assert property (@(posedge clk) disable iff (rst) bubble |-> (!pc_write && !ifid_write)); // R1
  AST_ENABLES_OPEN: assert property (@(posedge clk) disable iff (rst) !bubble |-> (pc_write && ifid_write)); // R3
  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (rst) !ex_is_load |-> !bubble); // R3
  AST_ZERO_REG_NO_STALL: assert property (@(posedge clk) disable iff (rst) (ex_rd == '0) |-> !bubble); // R5
  AST_BUBBLE_CTRL_ZERO: assert property (@(posedge clk) disable iff (rst) bubble |-> (idex_ctrl == '0)); // R9
  AST_CTRL_PASS: assert property (@(posedge clk) disable iff (rst) !bubble |-> (idex_ctrl == id_ctrl)); // R9
  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (rst) bubble |=> !bubble); // R10
endmodule

bind ldhaz_interlock ldhaz_interlock_chk #(.REG_AW(REG_AW), .CTRL_W(CTRL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ex_is_load (ex_is_load),
  .ex_rd      (ex_rd),
  .id_ctrl    (id_ctrl),
  .pc_write   (pc_write),
  .ifid_write (ifid_write),
  .bubble     (bubble),
  .idex_ctrl  (idex_ctrl)
);

// File: tb/sim_ldhaz_interlock.sv
`timescale 1ns/1ps
module sim_ldhaz_interlock;
  localparam int REG_AW = 5;
  localparam int NUM_SRC = 2;
  localparam int CTRL_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_SRC*REG_AW-1:0] id_rs_addr = '0;
  logic [NUM_SRC-1:0] id_rs_used = '0;
  logic id_is_store = 1'b0;
  logic [CTRL_W-1:0] id_ctrl = '0;
  logic ex_is_load = 1'b0;
  logic [REG_AW-1:0] ex_rd = '0;
  logic pc_write, ifid_write, bubble;
  logic [CTRL_W-1:0] idex_ctrl;

  int checks = 0;
  int failures = 0;
  bit prev_stall = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ldhaz_interlock #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W)) u0 (
    .clk(clk), .rst(rst), .id_rs_addr(id_rs_addr), .id_rs_used(id_rs_used),
    .id_is_store(id_is_store), .id_ctrl(id_ctrl), .ex_is_load(ex_is_load),
    .ex_rd(ex_rd), .pc_write(pc_write), .ifid_write(ifid_write),
    .bubble(bubble), .idex_ctrl(idex_ctrl)
  );

  function automatic bit want_hazard(input logic [REG_AW-1:0] s0, input logic [REG_AW-1:0] s1,
                                     input logic [1:0] used, input logic st,
                                     input logic ld, input logic [REG_AW-1:0] rd);
    bit h0, h1;
    h0 = used[0] && (s0 == rd);
    h1 = used[1] && (s1 == rd) && !st;
    return ld && (rd != 0) && (h0 || h1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [REG_AW-1:0] s0, input logic [REG_AW-1:0] s1,
                      input logic [1:0] used, input logic st, input logic [CTRL_W-1:0] c,
                      input logic ld, input logic [REG_AW-1:0] rd);
    bit exp_stall;
    @(posedge clk); #1;
    id_rs_addr = {s1, s0}; id_rs_used = used; id_is_store = st;
    id_ctrl = c; ex_is_load = ld; ex_rd = rd;
    exp_stall = want_hazard(s0, s1, used, st, ld, rd) && !prev_stall;
    @(negedge clk);
    check({tag, " bubble"}, {31'd0, bubble}, {31'd0, exp_stall});
    check({tag, " pc_write"}, {31'd0, pc_write}, {31'd0, !exp_stall});
    check({tag, " ifid_write"}, {31'd0, ifid_write}, {31'd0, !exp_stall});
    check("R9 idex_ctrl", {24'd0, idex_ctrl}, {24'd0, exp_stall ? 8'h00 : c});
    prev_stall = exp_stall;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit dummy;
    logic [REG_AW-1:0] rs0, rs1, rd;
    dummy = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    prev_stall = 1'b0;
    @(negedge clk);
    check("R11 reset bubble", {31'd0, bubble}, 32'd0);
    check("R11 reset pc_write", {31'd0, pc_write}, 32'd1);
    check("R11 reset ifid_write", {31'd0, ifid_write}, 32'd1);

    step("R11 first hazard", 5'd3, 5'd9, 2'b01, 1'b0, 8'hA5, 1'b1, 5'd3);
    step("R4 no match", 5'd4, 5'd9, 2'b11, 1'b0, 8'h5A, 1'b1, 5'd3);
    step("R2 src1", 5'd4, 5'd7, 2'b11, 1'b0, 8'h3C, 1'b1, 5'd7);
    step("R3 no load", 5'd7, 5'd7, 2'b11, 1'b0, 8'h11, 1'b0, 5'd7);
    step("R5 rd zero", 5'd0, 5'd0, 2'b11, 1'b0, 8'h22, 1'b1, 5'd0);
    step("R6 unused", 5'd6, 5'd6, 2'b00, 1'b0, 8'h33, 1'b1, 5'd6);
    step("R7 store data", 5'd2, 5'd6, 2'b11, 1'b1, 8'h44, 1'b1, 5'd6);
    step("R8 store base", 5'd6, 5'd2, 2'b11, 1'b1, 8'h55, 1'b1, 5'd6);
    step("R4 gap", 5'd1, 5'd2, 2'b11, 1'b0, 8'h66, 1'b0, 5'd9);
    step("R1 hold a", 5'd9, 5'd1, 2'b01, 1'b0, 8'h77, 1'b1, 5'd9);
    step("R10 held hazard released", 5'd9, 5'd1, 2'b01, 1'b0, 8'h77, 1'b1, 5'd9);
    step("R10 hazard stalls again", 5'd9, 5'd1, 2'b01, 1'b0, 8'h77, 1'b1, 5'd9);
    step("R4 idle", 5'd1, 5'd2, 2'b11, 1'b0, 8'h88, 1'b0, 5'd0);

    dummy = $urandom(32'h1234);
    for (int n = 0; n < 3000; n++) begin
      string tag;
      logic [1:0] used;
      logic st, ld;
      rs0 = 5'($urandom_range(0, 5));
      rs1 = 5'($urandom_range(0, 5));
      rd  = 5'($urandom_range(0, 5));
      used = 2'($urandom);
      st = 1'($urandom);
      ld = ($urandom_range(0, 3) != 0);
      if (!ld) tag = "R3 rand";
      else if (rd == 0) tag = "R5 rand";
      else if (prev_stall) tag = "R10 rand";
      else if (st && used[0] && rs0 == rd) tag = "R8 rand";
      else if (st && used[1] && rs1 == rd) tag = "R7 rand";
      else if (used[0] && rs0 == rd) tag = "R1 rand";
      else if (used[1] && rs1 == rd) tag = "R2 rand";
      else if ((rs0 == rd) || (rs1 == rd)) tag = "R6 rand";
      else tag = "R4 rand";
      step(tag, rs0, rs1, used, st, 8'($urandom), ld, rd);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule